// File: doc/BRIEF.md
# Real-IF Quadrature Mixer with Power Envelope

This block takes a stream of signed real samples at an intermediate frequency. It moves the band of interest to complex baseband. A numerically controlled oscillator supplies cosine and sine: a phase accumulator advances once per accepted sample and addresses a quarter-offset pair of reads from one sine table. The input has no imaginary part, so two real multipliers are enough. The in-phase branch multiplies the sample by cosine, and the quadrature branch multiplies it by sine.

Each product is kept at full width until the last rounding step. It is then rounded to the output width. The rounded pair feeds a power detector, which outputs I squared plus Q squared as a simple AM envelope with no root extraction. The tuning word is programmable. After reset it selects a 1 MHz offset at a 50 MS/s sample rate, which is round(2^32/50).

Top module: `iq_envelope_mixer`

## Requirements
- R1: After reset `out_valid` is low, `i_out`, `q_out` and `mag_sq` are zero, the phase accumulator is zero and the tuning register holds 0x051EB852. Samples in flight at reset produce no output.
- R2: The 32-bit phase accumulator adds the tuning register on every edge where `smp_valid` is high and holds otherwise. Each sample is mixed with the accumulator value present before its own increment.
- R3: Table entry a (0..1023) is round(32767*sin(2*pi*a/1024)), with rounding half up. The sine address is phase bits [31:22], and the cosine address is that value plus 256, modulo 1024. The outputs are I = (sample*cos + 2048) >>> 12 and Q = (sample*sin + 2048) >>> 12, using arithmetic shift, taken as 16-bit signed.
- R4: `mag_sq` is the unsigned 32-bit value I*I + Q*Q, computed from the same rounded I and Q presented beside it.
- R5: Every accepted sample produces exactly one `out_valid` pulse four clock edges later. Back-to-back samples give back-to-back outputs, and no output appears without an input.
- R6: `tune_load` stores `tune_word` on the edge where it is high. An increment taken on that same edge still uses the previous tuning value. The new value applies from the next accepted sample on.
- R7: Full-scale inputs (+2047 and -2048) against table peaks round as in R3 without wrap. |I| and |Q| never exceed 16384.
- R8: With a tuning word of zero the phase stays constant, so equal samples yield equal I, Q and `mag_sq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Signed IF sample |
| tune_load | input | 1 | Store `tune_word` into the tuning register |
| tune_word | input | 32 | New phase increment |
| out_valid | output | 1 | Result strobe, four edges after `smp_valid` |
| i_out | output | 16 | Rounded in-phase result |
| q_out | output | 16 | Rounded quadrature result |
| mag_sq | output | 32 | I*I + Q*Q |

## Verification
The bench uses the default parameters: 12-bit samples, a 32-bit accumulator, a 1024 x 16 table and 16-bit outputs. These bring the full-scale rounding extremes within reach. With them, tuning words of 1/16 and 1/8 turn land exactly on table peaks and zero crossings. The default 1 MHz word sweeps all four quadrants within 64 samples. A zero word, gapped input and a tuning load during a live stream then separate the hold, step and load-ordering rules of the accumulator.

// File: rtl/iqenv_pkg.sv
package iqenv_pkg;
  // Rounded sine sample for table index idx of depth entries, amplitude amp.
  function automatic int sine_entry(input int idx, input int depth, input int amp);
    real ang;
    real val;
    ang = 2.0 * 3.14159265358979323846 * real'(idx) / real'(depth);
    val = real'(amp) * $sin(ang);
    return $rtoi($floor(val + 0.5));
  endfunction
endpackage

// File: rtl/iqenv_nco.sv
module iqenv_nco #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int LUT_DW  = 16,
  parameter int SMP_W   = 12,
  parameter logic [PHASE_W-1:0] TUNE_RESET = 32'h051EB852
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SMP_W-1:0]  in_sample,
  input  logic                     tune_load,
  input  logic [PHASE_W-1:0]       tune_word,
  output logic                     out_valid,
  output logic signed [SMP_W-1:0]  out_sample,
  output logic signed [LUT_DW-1:0] sin_o,
  output logic signed [LUT_DW-1:0] cos_o
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int AMP   = (1 << (LUT_DW - 1)) - 1;
  localparam int QW    = 2 * LUT_DW + 1;
  localparam longint AMP_SQ = longint'(AMP) * longint'(AMP);
  localparam longint Q_TOL  = 4 * longint'(AMP);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] tune_q;
  logic [LUT_AW-1:0]  sin_addr;
  logic [LUT_AW-1:0]  cos_addr;
  logic signed [LUT_DW-1:0] rom [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom[k] = LUT_DW'(iqenv_pkg::sine_entry(k, DEPTH, AMP));
    end
  end

  assign sin_addr = acc_q[PHASE_W-1 -: LUT_AW];
  assign cos_addr = sin_addr + LUT_AW'(DEPTH / 4);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      tune_q    <= TUNE_RESET;
      out_valid <= 1'b0;
    end else begin
      if (in_valid) acc_q <= acc_q + tune_q;
      if (tune_load) tune_q <= tune_word;
      out_valid <= in_valid;
    end
  end

  // Table read port kept free of reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    sin_o      <= rom[sin_addr];
    cos_o      <= rom[cos_addr];
    out_sample <= in_sample;
  end

  logic signed [QW-1:0] s_ext, c_ext, q_sum;
  assign s_ext = QW'(sin_o);
  assign c_ext = QW'(cos_o);
  assign q_sum = s_ext * s_ext + c_ext * c_ext;

  // R3: the two reads stay a quarter turn apart (sin^2 + cos^2 near full scale)
  a_r3_quadrature: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(q_sum) <= AMP_SQ + Q_TOL) && (longint'(q_sum) >= AMP_SQ - Q_TOL));
endmodule

// File: rtl/iqenv_mixer.sv
module iqenv_mixer #(
  parameter int SMP_W  = 12,
  parameter int LUT_DW = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SMP_W-1:0]  in_sample,
  input  logic signed [LUT_DW-1:0] sin_i,
  input  logic signed [LUT_DW-1:0] cos_i,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  i_o,
  output logic signed [OUT_W-1:0]  q_o
);
  localparam int PROD_W = SMP_W + LUT_DW;
  localparam int DROP   = PROD_W - OUT_W;
  localparam longint PEAK = longint'(1 << (SMP_W - 1)) * longint'((1 << (LUT_DW - 1)) - 1);
  localparam longint LIM  = (DROP > 0) ? ((PEAK + (longint'(1) << (DROP - 1))) >>> DROP) : PEAK;

  logic signed [PROD_W-1:0] prod_i, prod_q;
  logic                     prod_v;
  logic signed [OUT_W-1:0]  rnd_i, rnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_i <= '0;
      prod_q <= '0;
      prod_v <= 1'b0;
    end else begin
      prod_i <= PROD_W'(in_sample) * PROD_W'(cos_i);
      prod_q <= PROD_W'(in_sample) * PROD_W'(sin_i);
      prod_v <= in_valid;
    end
  end

  generate
    if (DROP > 0) begin : g_round
      localparam logic signed [PROD_W:0] HALF = (PROD_W + 1)'(1) << (DROP - 1);
      logic signed [PROD_W:0] sum_i, sum_q;
      assign sum_i = (PROD_W + 1)'(prod_i) + HALF;
      assign sum_q = (PROD_W + 1)'(prod_q) + HALF;
      assign rnd_i = sum_i[PROD_W-1:DROP];
      assign rnd_q = sum_q[PROD_W-1:DROP];
    end else begin : g_pass
      assign rnd_i = OUT_W'(prod_i);
      assign rnd_q = OUT_W'(prod_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o       <= '0;
      q_o       <= '0;
      out_valid <= 1'b0;
    end else begin
      i_o       <= rnd_i;
      q_o       <= rnd_q;
      out_valid <= prod_v;
    end
  end

  // R7: rounded results stay inside the full-scale bound, no wrap
  a_r7_round_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (longint'(i_o) <= LIM) && (longint'(i_o) >= -LIM) &&
                  (longint'(q_o) <= LIM) && (longint'(q_o) >= -LIM));
endmodule

// File: rtl/iqenv_power.sv
module iqenv_power #(
  parameter int OUT_W = 16,
  parameter int MAG_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [OUT_W-1:0] i_i,
  input  logic signed [OUT_W-1:0] q_i,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o,
  output logic [MAG_W-1:0]        mag_o
);
  localparam int SQ_W = 2 * OUT_W;

  logic signed [SQ_W-1:0] sq_i, sq_q;
  logic [SQ_W:0]          sq_sum;

  assign sq_i   = SQ_W'(i_i) * SQ_W'(i_i);
  assign sq_q   = SQ_W'(q_i) * SQ_W'(q_i);
  assign sq_sum = {1'b0, sq_i} + {1'b0, sq_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o       <= '0;
      q_o       <= '0;
      mag_o     <= '0;
      out_valid <= 1'b0;
    end else begin
      i_o       <= i_i;
      q_o       <= q_i;
      mag_o     <= MAG_W'(sq_sum);
      out_valid <= in_valid;
    end
  end

  // R4: a nonzero I/Q pair never reports zero power
  a_r4_mag_nonzero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (i_o != '0 || q_o != '0)) |-> (mag_o != '0));
endmodule

// File: rtl/iq_envelope_mixer.sv
module iq_envelope_mixer #(
  parameter int SMP_W   = 12,
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 10,
  parameter int LUT_DW  = 16,
  parameter int OUT_W   = 16,
  parameter int MAG_W   = 32,
  parameter logic [PHASE_W-1:0] TUNE_RESET = 32'h051EB852
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic                    tune_load,
  input  logic [PHASE_W-1:0]      tune_word,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out,
  output logic [MAG_W-1:0]        mag_sq
);
  logic                     lo_v;
  logic signed [SMP_W-1:0]  lo_smp;
  logic signed [LUT_DW-1:0] lo_sin, lo_cos;
  logic                     mx_v;
  logic signed [OUT_W-1:0]  mx_i, mx_q;

  iqenv_nco #(
    .PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .LUT_DW(LUT_DW),
    .SMP_W(SMP_W), .TUNE_RESET(TUNE_RESET)
  ) u_nco (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_sample(smp_data),
    .tune_load(tune_load), .tune_word(tune_word),
    .out_valid(lo_v), .out_sample(lo_smp), .sin_o(lo_sin), .cos_o(lo_cos)
  );

  iqenv_mixer #(.SMP_W(SMP_W), .LUT_DW(LUT_DW), .OUT_W(OUT_W)) u_mix (
    .clk(clk), .rst(rst), .in_valid(lo_v), .in_sample(lo_smp),
    .sin_i(lo_sin), .cos_i(lo_cos),
    .out_valid(mx_v), .i_o(mx_i), .q_o(mx_q)
  );

  iqenv_power #(.OUT_W(OUT_W), .MAG_W(MAG_W)) u_pow (
    .clk(clk), .rst(rst), .in_valid(mx_v), .i_i(mx_i), .q_i(mx_q),
    .out_valid(out_valid), .i_o(i_out), .q_o(q_out), .mag_o(mag_sq)
  );

  // R5: every result strobe traces back to a sample four edges earlier
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_valid, 4));

  // R1: the first edge after reset shows no result
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/iq_envelope_mixer_tb.sv
module iq_envelope_mixer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DEF_TUNE = 32'h051EB852;
  localparam int FD = 512;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic               rst = 1'b1;
  logic               smp_valid = 1'b0;
  logic signed [11:0] smp_data = '0;
  logic               tune_load = 1'b0;
  logic [31:0]        tune_word = '0;
  logic               out_valid;
  logic signed [15:0] i_out, q_out;
  logic [31:0]        mag_sq;

  iq_envelope_mixer dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .tune_load(tune_load), .tune_word(tune_word),
    .out_valid(out_valid), .i_out(i_out), .q_out(q_out), .mag_sq(mag_sq)
  );

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint exp_i [FD];
  longint exp_q [FD];
  longint exp_m [FD];
  longint exp_t [FD];
  int wr = 0;
  int rd = 0;
  logic [31:0] acc_m = '0;
  logic [31:0] tune_m = DEF_TUNE;

  function automatic longint tbl(input int a);
    real x;
    x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 1024.0);
    return longint'($rtoi($floor(x + 0.5)));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Result monitor: compares every strobe against the model queue.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd == wr) begin
        check(1'b0, "R5", "strobe without input", 1, 0);
      end else begin
        check(longint'(i_out) == exp_i[rd % FD], "R3", "I value", longint'(i_out), exp_i[rd % FD]);
        check(longint'(q_out) == exp_q[rd % FD], "R3", "Q value", longint'(q_out), exp_q[rd % FD]);
        check(longint'(mag_sq) == exp_m[rd % FD], "R4", "magnitude", longint'(mag_sq), exp_m[rd % FD]);
        check(cyc == exp_t[rd % FD], "R5", "latency cycle", cyc, exp_t[rd % FD]);
        rd++;
      end
    end
  end

  task automatic drive(input int smp, input bit ld, input logic [31:0] w);
    logic [9:0] a;
    longint s, c, pi, pq, ei, eq;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = 12'(smp);
    tune_load = ld;
    tune_word = w;
    a  = acc_m[31:22];
    s  = tbl(int'(a));
    c  = tbl(int'(10'(a + 10'd256)));
    pi = longint'(smp) * c;
    pq = longint'(smp) * s;
    ei = (pi + 2048) >>> 12;
    eq = (pq + 2048) >>> 12;
    exp_i[wr % FD] = ei;
    exp_q[wr % FD] = eq;
    exp_m[wr % FD] = ei * ei + eq * eq;
    exp_t[wr % FD] = cyc + 4;
    wr++;
    acc_m = acc_m + tune_m;
    if (ld) tune_m = w;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      tune_load = 1'b0;
    end
  endtask

  task automatic load_tune(input logic [31:0] w);
    @(negedge clk);
    smp_valid = 1'b0;
    tune_load = 1'b1;
    tune_word = w;
    @(posedge clk);
    tune_m = w;
    @(negedge clk);
    tune_load = 1'b0;
  endtask

  task automatic drain(input string req);
    idle(8);
    check(rd == wr, req, "results delivered", rd, wr);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    smp_valid = 1'b0;
    tune_load = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    check(i_out == '0, "R1", "I in reset", i_out, 0);
    check(q_out == '0, "R1", "Q in reset", q_out, 0);
    check(mag_sq == '0, "R1", "mag in reset", mag_sq, 0);
    rst = 1'b0;
    acc_m = '0;
    tune_m = DEF_TUNE;
    rd = wr;
  endtask

  // R1 R2 R3 R4 R5: default tuning word, constant amplitude, back to back
  task automatic t_default_burst();
    for (int k = 0; k < 64; k++) drive(1500, 1'b0, '0);
    drain("R5");
  endtask

  // R2: idle cycles must not advance the phase
  task automatic t_gapped();
    for (int k = 0; k < 20; k++) begin
      drive((k * 373) % 4096 - 2048, 1'b0, '0);
      idle(k % 4);
    end
    drain("R2");
  endtask

  // R7 R6: full-scale inputs against table peaks and zeros
  task automatic t_extremes();
    load_tune(32'h1000_0000);
    for (int k = 0; k < 32; k++) drive((k % 2 == 0) ? 2047 : -2048, 1'b0, '0);
    drain("R7");
  endtask

  // R8: zero step keeps phase fixed
  task automatic t_zero_tune();
    load_tune(32'h0000_0000);
    for (int k = 0; k < 16; k++) drive(-700 + 100 * (k % 3), 1'b0, '0);
    drain("R8");
  endtask

  // R6: tuning load on the same edge as a live sample
  task automatic t_load_inflight();
    load_tune(32'h0300_0000);
    for (int k = 0; k < 12; k++) drive(1200, k == 5, 32'h2000_0000);
    for (int k = 0; k < 12; k++) drive(-900, 1'b0, '0);
    drain("R6");
  endtask

  // R1: reset drops in-flight samples and restores defaults
  task automatic t_reset_mid();
    load_tune(32'h4000_0000);
    for (int k = 0; k < 3; k++) drive(1800, 1'b0, '0);
    reset_dut();
    idle(6);
    check(rd == wr, "R1", "no stale results", rd, wr);
    for (int k = 0; k < 10; k++) drive(1800, 1'b0, '0);
    drain("R1");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL R5 watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reset_dut();
    t_default_burst();
    t_gapped();
    t_extremes();
    t_zero_tune();
    t_load_inflight();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule